// File: doc/BRIEF.md
# DRAM Command Scheduler

This block schedules read requests for one DRAM channel that serves several banks. Requests enter a small age-ordered queue. Each request carries a bank, a row and a thread tag. The scheduler keeps, for every bank, whether a row is open, which row that is, and how long the bank stays occupied by its last command. Each cycle it may place one command on the shared command bus. The command is PRECHARGE, ACTIVATE or READ, and it is chosen from the queued requests whose next step is legal in that cycle. One cycle stands for one nanosecond of DRAM time.

Two policies can be selected. In first-ready mode, a legal READ to an already open row goes ahead of any other legal command. Among requests of equal rank, the oldest goes first. In strict in-order mode, only the oldest request that has not yet issued its READ may advance. Every command keeps its bank busy for ten cycles. A READ that hits the row left open by an earlier READ can follow that READ after five cycles, so hits to one bank overlap their bank time. Each READ claims the shared data bus for five cycles, starting ten cycles after the READ. The scheduler spaces READs across all banks so that these windows never collide. When a transfer ends, the request leaves the queue and a one-cycle completion pulse returns its thread tag.

Top module: `mem_sched`

## Requirements
- R1: After reset, cmd_valid_o, data_valid_o and done_o are low, req_ready_o is high, and every bank row is closed.
- R2: The first access to a closed bank issues ACTIVATE and then READ to that bank, ten cycles apart. cmd_kind_o encodes 1 = PRECHARGE, 2 = ACTIVATE, 3 = READ.
- R3: A request whose bank has a different row open receives PRECHARGE, ACTIVATE and READ in that order. Any two commands to one bank are at least ten cycles apart, except in the case covered by R4.
- R4: A READ that hits the open row of a bank whose previous command was a READ may issue five cycles after that READ.
- R5: data_valid_o is high for exactly five cycles, starting ten cycles after a READ is issued.
- R6: Any two READs on the channel are at least five cycles apart, whatever their banks, so data windows never overlap. A READ to a second bank waits for the data bus even when that bank is ready.
- R7: done_o pulses for one cycle in the cycle after a request's last data cycle, with done_tid_o equal to that request's tag. The request then leaves the queue.
- R8: With frfcfs_i high, a legal row-hit READ is chosen before an older request that needs a PRECHARGE.
- R9: With frfcfs_i low, only the oldest request without an issued READ may receive a command. Younger row hits wait behind it.
- R10: req_ready_o is low while the queue holds QDEPTH requests. A request offered while it is low is dropped: it is never issued and never completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one cycle per nanosecond of DRAM time |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frfcfs_i | input | 1 | 1 = row hits first, 0 = strict arrival order |
| req_valid_i | input | 1 | New read request offered |
| req_bank_i | input | BANK_W | Bank of the request |
| req_row_i | input | ROW_W | Row of the request |
| req_tid_i | input | TID_W | Thread tag of the request |
| req_ready_o | output | 1 | Queue has a free slot |
| cmd_valid_o | output | 1 | A command is on the command bus this cycle |
| cmd_kind_o | output | 2 | 1 PRECHARGE, 2 ACTIVATE, 3 READ |
| cmd_bank_o | output | BANK_W | Target bank of the command |
| cmd_row_o | output | ROW_W | Row of the request that owns the command |
| data_valid_o | output | 1 | Data bus carries a transfer this cycle |
| done_o | output | 1 | A request finished its transfer |
| done_tid_o | output | TID_W | Thread tag of the finished request |

## Verification
The hardest case to reach is the one where the two policies disagree. An older request must need a PRECHARGE at the same moment a younger request could hit the open row. The stimulus sets this up by opening a row with one request and then queueing a conflicting request followed by a hit, all while the bank is still busy from the ACTIVATE. When the bank frees, both candidates are legal together. The same three-request pattern is run under each policy, and the command order, the hit spacing and the completion order are compared. A second stimulus opens two idle banks on consecutive cycles, so that the second READ is ready but blocked by the data bus.

// File: rtl/mem_sched_pkg.sv
package mem_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_PRE  = 2'b01,
    CMD_ACT  = 2'b10,
    CMD_RD   = 2'b11
  } cmd_e;
endpackage

// File: rtl/mem_sched_bank.sv
module mem_sched_bank
  import mem_sched_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int T_BANK = 10,
  parameter int T_HIT  = 5,
  localparam int CW    = $clog2(T_BANK + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  cmd_e             cmd_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             cmd_ok_o,
  output logic             rd_ok_o
);
  logic [CW-1:0] busy_q, hit_q;
  logic          issue;

  assign issue = sel_i && (cmd_i != CMD_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= '0;
      hit_q      <= '0;
      open_o     <= 1'b0;
      open_row_o <= '0;
    end else if (issue) begin
      busy_q <= CW'(T_BANK - 1);
      hit_q  <= (cmd_i == CMD_RD) ? CW'(T_HIT - 1) : CW'(T_BANK - 1);
      if (cmd_i == CMD_PRE) open_o <= 1'b0;
      if (cmd_i == CMD_ACT) begin
        open_o     <= 1'b1;
        open_row_o <= row_i;
      end
    end else begin
      if (busy_q != '0) busy_q <= busy_q - 1'b1;
      if (hit_q != '0)  hit_q  <= hit_q - 1'b1;
    end
  end

  assign cmd_ok_o = (busy_q == '0);
  assign rd_ok_o  = (hit_q == '0);

  // independent spacing monitor for the checks below
  logic [CW-1:0] since_q;
  logic          last_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q   <= CW'(T_BANK);
      last_rd_q <= 1'b0;
    end else if (issue) begin
      since_q   <= CW'(1);
      last_rd_q <= (cmd_i == CMD_RD);
    end else if (since_q < CW'(T_BANK)) begin
      since_q <= since_q + 1'b1;
    end
  end

  // R2
  act_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && cmd_i == CMD_ACT |-> !open_o);
  // R2
  rd_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && cmd_i == CMD_RD |-> open_o && open_row_o == row_i);
  // R3
  bank_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && cmd_i != CMD_RD |-> since_q >= CW'(T_BANK));
  // R4
  hit_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue && cmd_i == CMD_RD |-> since_q >= (last_rd_q ? CW'(T_HIT) : CW'(T_BANK)));
endmodule

// File: rtl/mem_sched_queue.sv
module mem_sched_queue #(
  parameter int DEPTH   = 4,
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 4,
  parameter int TID_W   = 2,
  parameter int T_BANK  = 10,
  parameter int T_BURST = 5,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int TW     = $clog2(T_BANK + T_BURST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [BANK_W-1:0] push_bank_i,
  input  logic [ROW_W-1:0]  push_row_i,
  input  logic [TID_W-1:0]  push_tid_i,
  output logic              full_o,
  input  logic              mark_i,
  input  logic [IDX_W-1:0]  mark_idx_i,
  output logic              vld_o  [DEPTH],
  output logic [BANK_W-1:0] bank_o [DEPTH],
  output logic [ROW_W-1:0]  row_o  [DEPTH],
  output logic              iss_o  [DEPTH],
  output logic              done_o,
  output logic [TID_W-1:0]  done_tid_o,
  output logic              data_valid_o
);
  logic              vld_q [DEPTH], vld_n [DEPTH], iss_q [DEPTH], iss_n [DEPTH];
  logic [BANK_W-1:0] bank_q [DEPTH], bank_n [DEPTH];
  logic [ROW_W-1:0]  row_q [DEPTH], row_n [DEPTH];
  logic [TID_W-1:0]  tid_q [DEPTH], tid_n [DEPTH];
  logic [TW-1:0]     cnt_q [DEPTH], cnt_n [DEPTH];
  logic              t_iss [DEPTH];
  logic [TW-1:0]     t_cnt [DEPTH];
  logic [CW-1:0]     count_q, count_n, cnt_rem;
  logic [IDX_W-1:0]  done_idx;
  logic              do_push;

  assign full_o  = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign vld_o   = vld_q;
  assign bank_o  = bank_q;
  assign row_o   = row_q;
  assign iss_o   = iss_q;

  always_comb begin
    done_o       = 1'b0;
    done_idx     = '0;
    data_valid_o = 1'b0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vld_q[i] && iss_q[i] && cnt_q[i] == '0) begin
        done_o   = 1'b1;
        done_idx = IDX_W'(i);
      end
      if (vld_q[i] && iss_q[i] && cnt_q[i] != '0 && cnt_q[i] <= TW'(T_BURST))
        data_valid_o = 1'b1;
    end
    done_tid_o = tid_q[done_idx];
    // advance read timers, then mark the newly read entry
    for (int i = 0; i < DEPTH; i++) begin
      t_iss[i] = iss_q[i];
      t_cnt[i] = (iss_q[i] && cnt_q[i] != '0) ? cnt_q[i] - 1'b1 : cnt_q[i];
      if (mark_i && mark_idx_i == IDX_W'(i)) begin
        t_iss[i] = 1'b1;
        t_cnt[i] = TW'(T_BANK + T_BURST - 1);
      end
    end
    // close the gap left by a finished entry, keeping age order
    for (int j = 0; j < DEPTH; j++) begin
      int src;
      src = (done_o && j >= int'(done_idx)) ? j + 1 : j;
      if (src < DEPTH) begin
        vld_n[j]  = vld_q[src];
        bank_n[j] = bank_q[src];
        row_n[j]  = row_q[src];
        tid_n[j]  = tid_q[src];
        iss_n[j]  = t_iss[src];
        cnt_n[j]  = t_cnt[src];
      end else begin
        vld_n[j]  = 1'b0;
        bank_n[j] = '0;
        row_n[j]  = '0;
        tid_n[j]  = '0;
        iss_n[j]  = 1'b0;
        cnt_n[j]  = '0;
      end
    end
    cnt_rem = count_q - CW'(done_o);
    if (do_push) begin
      vld_n[IDX_W'(cnt_rem)]  = 1'b1;
      bank_n[IDX_W'(cnt_rem)] = push_bank_i;
      row_n[IDX_W'(cnt_rem)]  = push_row_i;
      tid_n[IDX_W'(cnt_rem)]  = push_tid_i;
      iss_n[IDX_W'(cnt_rem)]  = 1'b0;
      cnt_n[IDX_W'(cnt_rem)]  = '0;
    end
    count_n = cnt_rem + CW'(do_push);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        vld_q[i]  <= 1'b0;
        bank_q[i] <= '0;
        row_q[i]  <= '0;
        tid_q[i]  <= '0;
        iss_q[i]  <= 1'b0;
        cnt_q[i]  <= '0;
      end
    end else begin
      count_q <= count_n;
      vld_q   <= vld_n;
      bank_q  <= bank_n;
      row_q   <= row_n;
      tid_q   <= tid_n;
      iss_q   <= iss_n;
      cnt_q   <= cnt_n;
    end
  end

  // R10
  depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  // R10
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !done_o |=> full_o);
  // R7
  done_after_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(data_valid_o));
endmodule

// File: rtl/mem_sched.sv
module mem_sched
  import mem_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 4,
  parameter int TID_W     = 2,
  parameter int QDEPTH    = 4,
  parameter int T_BANK    = 10,
  parameter int T_BURST   = 5,
  parameter int T_HIT     = 5,
  localparam int BANK_W   = $clog2(NUM_BANKS),
  localparam int IDX_W    = $clog2(QDEPTH),
  localparam int DB_W     = $clog2(T_BANK + T_BURST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frfcfs_i,
  input  logic              req_valid_i,
  input  logic [BANK_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]  req_row_i,
  input  logic [TID_W-1:0]  req_tid_i,
  output logic              req_ready_o,
  output logic              cmd_valid_o,
  output logic [1:0]        cmd_kind_o,
  output logic [BANK_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]  cmd_row_o,
  output logic              data_valid_o,
  output logic              done_o,
  output logic [TID_W-1:0]  done_tid_o
);
  logic              q_vld [QDEPTH], q_iss [QDEPTH];
  logic [BANK_W-1:0] q_bank [QDEPTH];
  logic [ROW_W-1:0]  q_row [QDEPTH];
  logic              q_full;
  logic              bk_open [NUM_BANKS], bk_cmd_ok [NUM_BANKS], bk_rd_ok [NUM_BANKS];
  logic [ROW_W-1:0]  bk_row [NUM_BANKS];
  logic              e_hit [QDEPTH], e_wait [QDEPTH], e_legal [QDEPTH];
  cmd_e              e_kind [QDEPTH];
  logic              go, any_legal, any_hit, any_wait;
  logic [IDX_W-1:0]  pick, first_legal, first_hit, oldest;
  cmd_e              kind_sel;
  logic [DB_W-1:0]   db_cnt_q;
  logic              rd_issue;

  assign req_ready_o = !q_full;

  mem_sched_queue #(
    .DEPTH(QDEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W), .TID_W(TID_W),
    .T_BANK(T_BANK), .T_BURST(T_BURST)
  ) u_queue (
    .clk_i, .rst_ni,
    .push_i(req_valid_i), .push_bank_i(req_bank_i), .push_row_i(req_row_i),
    .push_tid_i(req_tid_i), .full_o(q_full),
    .mark_i(rd_issue), .mark_idx_i(pick),
    .vld_o(q_vld), .bank_o(q_bank), .row_o(q_row), .iss_o(q_iss),
    .done_o, .done_tid_o, .data_valid_o
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    mem_sched_bank #(.ROW_W(ROW_W), .T_BANK(T_BANK), .T_HIT(T_HIT)) u_bank (
      .clk_i, .rst_ni,
      .sel_i(go && cmd_bank_o == BANK_W'(g)),
      .cmd_i(kind_sel), .row_i(cmd_row_o),
      .open_o(bk_open[g]), .open_row_o(bk_row[g]),
      .cmd_ok_o(bk_cmd_ok[g]), .rd_ok_o(bk_rd_ok[g])
    );
  end

  // next command of every waiting request and whether it may go now
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) begin
      e_hit[i]   = bk_open[q_bank[i]] && bk_row[q_bank[i]] == q_row[i];
      e_kind[i]  = e_hit[i] ? CMD_RD : (bk_open[q_bank[i]] ? CMD_PRE : CMD_ACT);
      e_wait[i]  = q_vld[i] && !q_iss[i];
      e_legal[i] = e_wait[i] && (e_hit[i]
                   ? (bk_rd_ok[q_bank[i]] && db_cnt_q <= DB_W'(T_BANK))
                   : bk_cmd_ok[q_bank[i]]);
    end
  end

  always_comb begin
    any_legal = 1'b0; first_legal = '0;
    any_hit   = 1'b0; first_hit   = '0;
    any_wait  = 1'b0; oldest      = '0;
    for (int i = QDEPTH - 1; i >= 0; i--) begin
      if (e_legal[i]) begin any_legal = 1'b1; first_legal = IDX_W'(i); end
      if (e_legal[i] && e_hit[i]) begin any_hit = 1'b1; first_hit = IDX_W'(i); end
      if (e_wait[i]) begin any_wait = 1'b1; oldest = IDX_W'(i); end
    end
    if (frfcfs_i) begin
      go   = any_legal;
      pick = any_hit ? first_hit : first_legal;
    end else begin
      go   = any_wait && e_legal[oldest];
      pick = oldest;
    end
  end

  assign kind_sel    = go ? e_kind[pick] : CMD_NONE;
  assign cmd_valid_o = go;
  assign cmd_kind_o  = kind_sel;
  assign cmd_bank_o  = q_bank[pick];
  assign cmd_row_o   = q_row[pick];
  assign rd_issue    = go && e_kind[pick] == CMD_RD;

  // cycles until the last claimed data window has ended
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               db_cnt_q <= '0;
    else if (rd_issue)         db_cnt_q <= DB_W'(T_BANK + T_BURST - 1);
    else if (db_cnt_q != '0)   db_cnt_q <= db_cnt_q - 1'b1;
  end

  logic [DB_W-1:0] rd_gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rd_gap_q <= DB_W'(T_BURST);
    else if (cmd_valid_o && cmd_kind_o == 2'b11) rd_gap_q <= DB_W'(1);
    else if (rd_gap_q < DB_W'(T_BURST))  rd_gap_q <= rd_gap_q + 1'b1;
  end

  // R6
  data_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && cmd_kind_o == 2'b11 |-> rd_gap_q >= DB_W'(T_BURST));
endmodule

// File: tb/mem_sched_test.sv
module mem_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frfcfs = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_bank = '0;
  logic [3:0] req_row = '0;
  logic [1:0] req_tid = '0;
  logic       req_ready, cmd_valid, data_valid, done;
  logic [1:0] cmd_kind, cmd_bank, done_tid;
  logic [3:0] cmd_row;

  int n_checks = 0, n_fail = 0, cyc = 0;
  int ncmd = 0, ndv = 0, ndone = 0;
  int c_cyc [512], c_kind [512], c_bank [512], c_row [512];
  int dv_cyc [512], d_cyc [512], d_tid [512];

  always #10 clk = ~clk;

  mem_sched uut (
    .clk_i(clk), .rst_ni(rst_n), .frfcfs_i(frfcfs),
    .req_valid_i(req_valid), .req_bank_i(req_bank), .req_row_i(req_row),
    .req_tid_i(req_tid), .req_ready_o(req_ready),
    .cmd_valid_o(cmd_valid), .cmd_kind_o(cmd_kind), .cmd_bank_o(cmd_bank),
    .cmd_row_o(cmd_row), .data_valid_o(data_valid), .done_o(done),
    .done_tid_o(done_tid)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd_valid && ncmd < 512) begin
        c_cyc[ncmd] = cyc; c_kind[ncmd] = int'(cmd_kind);
        c_bank[ncmd] = int'(cmd_bank); c_row[ncmd] = int'(cmd_row);
        ncmd++;
      end
      if (data_valid && ndv < 512) begin dv_cyc[ndv] = cyc; ndv++; end
      if (done && ndone < 512) begin
        d_cyc[ndone] = cyc; d_tid[ndone] = int'(done_tid); ndone++;
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic push(int bank, int row, int tid);
    @(negedge clk);
    req_valid = 1'b1; req_bank = 2'(bank); req_row = 4'(row); req_tid = 2'(tid);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic do_reset(logic mode);
    frfcfs = mode;
    rst_n = 1'b0;
    idle(3);
    @(negedge clk) rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset(1'b1);
    @(negedge clk);
    check("R1 cmd_valid", int'(cmd_valid), 0);
    check("R1 data_valid", int'(data_valid), 0);
    check("R1 done", int'(done), 0);
    check("R1 ready", int'(req_ready), 1);
  endtask

  task automatic t_closed_bank();
    int b = ncmd, bd = ndv, bn = ndone;
    push(0, 3, 1);
    idle(45);
    check("R2 command count", ncmd - b, 2);
    check("R2 first is ACT", c_kind[b], 2);
    check("R2 ACT row", c_row[b], 3);
    check("R2 then READ", c_kind[b+1], 3);
    check("R2 ACT to READ gap", c_cyc[b+1] - c_cyc[b], 10);
    check("R5 data cycles", ndv - bd, 5);
    check("R5 data start", dv_cyc[bd] - c_cyc[b+1], 10);
    check("R5 data end", dv_cyc[bd+4] - c_cyc[b+1], 14);
    check("R7 one done", ndone - bn, 1);
    check("R7 done cycle", d_cyc[bn] - c_cyc[b+1], 15);
    check("R7 done tid", d_tid[bn], 1);
  endtask

  task automatic t_hits();
    int b = ncmd, bd = ndv, bn = ndone;
    push(0, 3, 2);
    push(0, 3, 3);
    idle(40);
    check("R4 two reads", ncmd - b, 2);
    check("R4 both READ", c_kind[b] + c_kind[b+1], 6);
    check("R4 hit gap", c_cyc[b+1] - c_cyc[b], 5);
    check("R5 back to back data", ndv - bd, 10);
    check("R5 data contiguous", dv_cyc[bd+9] - dv_cyc[bd], 9);
    check("R7 first tid", d_tid[bn], 2);
    check("R7 second tid", d_tid[bn+1], 3);
    check("R7 done spacing", d_cyc[bn+1] - d_cyc[bn], 5);
  endtask

  task automatic t_conflict();
    int b = ncmd, bn = ndone;
    push(0, 7, 0);
    idle(50);
    check("R3 count", ncmd - b, 3);
    check("R3 PRE first", c_kind[b], 1);
    check("R3 ACT second", c_kind[b+1], 2);
    check("R3 READ third", c_kind[b+2], 3);
    check("R3 PRE to ACT", c_cyc[b+1] - c_cyc[b], 10);
    check("R3 ACT to READ", c_cyc[b+2] - c_cyc[b+1], 10);
    check("R7 conflict done", d_cyc[bn] - c_cyc[b+2], 15);
  endtask

  task automatic t_first_ready();
    int b, bn;
    do_reset(1'b1);
    b = ncmd; bn = ndone;
    push(0, 2, 0);
    push(0, 5, 1);
    push(0, 2, 2);
    idle(100);
    check("R8 count", ncmd - b, 6);
    check("R8 hit READ before PRE", c_kind[b+2], 3);
    check("R8 hit row", c_row[b+2], 2);
    check("R4 hit spacing", c_cyc[b+2] - c_cyc[b+1], 5);
    check("R3 PRE waits bank", c_cyc[b+3] - c_cyc[b+2], 10);
    check("R8 done order 0", d_tid[bn], 0);
    check("R8 done order 1", d_tid[bn+1], 2);
    check("R8 done order 2", d_tid[bn+2], 1);
  endtask

  task automatic t_in_order();
    int b, bn;
    do_reset(1'b0);
    b = ncmd; bn = ndone;
    push(0, 2, 0);
    push(0, 5, 1);
    push(0, 2, 2);
    idle(130);
    check("R9 count", ncmd - b, 8);
    check("R9 PRE for oldest", c_kind[b+2], 1);
    check("R9 PRE row", c_row[b+2], 5);
    check("R9 PRE timing", c_cyc[b+2] - c_cyc[b+1], 10);
    check("R9 done order 0", d_tid[bn], 0);
    check("R9 done order 1", d_tid[bn+1], 1);
    check("R9 done order 2", d_tid[bn+2], 2);
  endtask

  task automatic t_data_bus();
    int b, bd;
    do_reset(1'b1);
    b = ncmd; bd = ndv;
    push(1, 0, 1);
    push(2, 0, 2);
    idle(45);
    check("R6 count", ncmd - b, 4);
    check("R6 ACT bank1", c_bank[b], 1);
    check("R6 ACT bank2 next cycle", c_cyc[b+1] - c_cyc[b], 1);
    check("R6 READ bank1", c_cyc[b+2] - c_cyc[b], 10);
    check("R6 READ bank2 bank", c_bank[b+3], 2);
    check("R6 READ spacing", c_cyc[b+3] - c_cyc[b+2], 5);
    check("R6 data cycles", ndv - bd, 10);
    check("R6 no gap no overlap", dv_cyc[bd+9] - dv_cyc[bd], 9);
  endtask

  task automatic t_full();
    int b, bn, bad_tid = 0, bad_row = 0;
    do_reset(1'b1);
    b = ncmd; bn = ndone;
    push(3, 1, 0);
    push(3, 2, 1);
    push(3, 3, 2);
    push(3, 4, 0);
    @(negedge clk);
    check("R10 ready low when full", int'(req_ready), 0);
    push(3, 9, 3);
    idle(250);
    check("R10 four done", ndone - bn, 4);
    for (int i = bn; i < ndone; i++) if (d_tid[i] == 3) bad_tid++;
    for (int i = b; i < ncmd; i++) if (c_row[i] == 9) bad_row++;
    check("R10 dropped never done", bad_tid, 0);
    check("R10 dropped never issued", bad_row, 0);
    check("R10 ready again", int'(req_ready), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_closed_bank();
    t_hits();
    t_conflict();
    t_first_ready();
    t_in_order();
    t_data_bus();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule